// File: doc/BRIEF.md
# Base-Register Tag-Check Elision Unit

This unit sits ahead of a level-one data cache and its data TLB. For every load or store it looks up a small table, one entry per architectural base register, and decides whether the access can go straight to one known cache way without a tag compare or a translation. An entry remembers the base value last used through that register, the cache set and way of the line it reached, and the window of offsets that keep base plus offset inside that 32-byte line. A lookup whose base matches and whose offset lies in the window gets an elide grant with the set and way. Any other lookup gets a request for the normal parallel tag lookup.

After a normal lookup hits, the cache reports the access back on the fill port and the entry is rebuilt. A write to a base register clears that register's entry. An eviction or invalidation of a cache line clears, through a compare against every entry at once, all entries that name that set and way. Two free-running counters report how many accesses were elided and how many went to the full path.

The response path is a three-state machine: `RSP_IDLE` (no response this cycle), `RSP_ELIDE` (elide grant) and `RSP_FULL` (full lookup request). From any state it moves to `RSP_ELIDE` when a request arrives and the table check passes, to `RSP_FULL` when a request arrives and the check fails, and to `RSP_IDLE` when no request arrives.

Top module: `breg_elide_unit`

## Requirements
- R1: After reset `rsp_valid` is 0, both counters are 0 and every table entry is invalid, so the first lookup through any register gets a full-lookup response.
- R2: A request whose register entry is valid, whose base equals the stored base and whose offset lies in the stored window gives, one cycle later, `rsp_valid`=1, `rsp_elide`=1 and the stored set and way on `rsp_set`/`rsp_way`.
- R3: Any other request gives, one cycle later, `rsp_valid`=1, `rsp_elide`=0, `rsp_set`=0 and `rsp_way`=0.
- R4: A fill with base B and signed offset F makes later requests through the same register with base B elide exactly when B+O (modulo 2^32, O sign-extended) lies in the same 32-byte aligned line as B+F; the first and last byte of the line elide, the bytes just outside do not.
- R5: A register write clears that register's entry for every later request; when a fill and a register write target the same register in one cycle, the entry ends up invalid.
- R6: An eviction clears every entry whose set and way both equal the evicted ones, including an entry filled in the same cycle with that set and way; entries with a different set or way keep eliding.
- R7: A request is checked against the table as it stood before the fills, register writes and evictions presented in the same cycle.
- R8: `elided_count` rises by one in the cycle each elide response appears and `full_count` rises by one in the cycle each full response appears; both wrap modulo 2^16.
- R9: A request through a register whose entry holds a different base value gets a full-lookup response even when the offset lies in the window.
- R10: A cycle with no request gives `rsp_valid`=0 one cycle later and leaves both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_reg | input | 5 | Base-register number of the access |
| req_base | input | 32 | Base register value |
| req_off | input | 16 | Signed byte offset |
| rsp_valid | output | 1 | A response is presented |
| rsp_elide | output | 1 | 1: elide grant, 0: full lookup needed |
| rsp_set | output | 6 | Set of the granted line (0 on full) |
| rsp_way | output | 2 | Way of the granted line (0 on full) |
| fill_valid | input | 1 | A full lookup hit; rebuild an entry |
| fill_reg | input | 5 | Base register of that access |
| fill_base | input | 32 | Base value of that access |
| fill_off | input | 16 | Signed offset of that access |
| fill_set | input | 6 | Set where it hit |
| fill_way | input | 2 | Way where it hit |
| rwr_valid | input | 1 | A base register is being written |
| rwr_reg | input | 5 | Number of the written register |
| evict_valid | input | 1 | A cache line is evicted or invalidated |
| evict_set | input | 6 | Set of that line |
| evict_way | input | 2 | Way of that line |
| elided_count | output | 16 | Count of elide responses |
| full_count | output | 16 | Count of full-lookup responses |

## Verification
Every response and both counter updates are due exactly one clock after the request is sampled, and a fill, register write or eviction first affects a request sampled one clock after it. The bench drives inputs on the falling edge, updates its behavioural table on the rising edge in the same order the requirements state (request check first, then fill, register clear, line clear), and compares all outputs on the next falling edge, so each response is matched against the request of the preceding cycle. Directed sequences place the window edges, same-cycle collisions and the counter wrap at known cycles, and a random stream mixes all inputs over a few registers and bases.

// File: rtl/breg_elide_pkg.sv
package breg_elide_pkg;

    // Response state of the unit; one response per request, one cycle later.
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_ELIDE = 2'd1,
        RSP_FULL  = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/elide_window.sv
// Offset window arithmetic: builds the low bound on refill and tests a
// request offset against a stored low bound. The window spans one line.
module elide_window #(
    parameter int OFF_W      = 16,
    parameter int LINE_SHIFT = 5
) (
    input  logic [OFF_W-1:0]      fill_off,
    input  logic [LINE_SHIFT-1:0] fill_byte,
    output logic [OFF_W:0]        fill_lo,
    input  logic [OFF_W-1:0]      chk_off,
    input  logic [OFF_W:0]        chk_lo,
    output logic                  chk_in
);
    localparam int XW = OFF_W + 2;

    logic signed [XW-1:0] off_x;
    logic signed [XW-1:0] lo_x;
    logic signed [XW-1:0] hi_x;

    // Lowest offset still inside the line: offset minus its byte position.
    always_comb begin
        fill_lo = {fill_off[OFF_W-1], fill_off}
                - {{(OFF_W + 1 - LINE_SHIFT){1'b0}}, fill_byte};
    end

    always_comb begin
        off_x  = $signed({{2{chk_off[OFF_W-1]}}, chk_off});
        lo_x   = $signed({chk_lo[OFF_W], chk_lo});
        hi_x   = lo_x + $signed(XW'((1 << LINE_SHIFT) - 1));
        chk_in = (off_x >= lo_x) && (off_x <= hi_x);
    end

endmodule

// File: rtl/elide_table.sv
// One entry per base register; single write port for refills, per-register
// clear, and a broadcast set/way clear over all entries.
module elide_table #(
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 16,
    parameter int SET_W    = 6,
    parameter int WAY_W    = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_base,
    output logic [OFF_W:0]    rd_lo,
    output logic [SET_W-1:0]  rd_set,
    output logic [WAY_W-1:0]  rd_way,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [OFF_W:0]    wr_lo,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic              clr_reg_en,
    input  logic [REG_W-1:0]  clr_reg_idx,
    input  logic              clr_line_en,
    input  logic [SET_W-1:0]  clr_set,
    input  logic [WAY_W-1:0]  clr_way
);
    logic              v_q    [NUM_REGS];
    logic [ADDR_W-1:0] base_q [NUM_REGS];
    logic [OFF_W:0]    lo_q   [NUM_REGS];
    logic [SET_W-1:0]  set_q  [NUM_REGS];
    logic [WAY_W-1:0]  way_q  [NUM_REGS];

    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] kill;

    // Per-entry decode of the write and of both clear sources.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        logic line_match;
        always_comb begin
            wr_hit[i]  = wr_en && (wr_idx == REG_W'(i));
            // Entry's target after this cycle's write decides the line clear.
            line_match = wr_hit[i] ? ((wr_set == clr_set) && (wr_way == clr_way))
                                   : ((set_q[i] == clr_set) && (way_q[i] == clr_way));
            kill[i]    = (clr_reg_en && (clr_reg_idx == REG_W'(i)))
                       || (clr_line_en && line_match);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                v_q[i]    <= 1'b0;
                base_q[i] <= '0;
                lo_q[i]   <= '0;
                set_q[i]  <= '0;
                way_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_hit[i]) begin
                    base_q[i] <= wr_base;
                    lo_q[i]   <= wr_lo;
                    set_q[i]  <= wr_set;
                    way_q[i]  <= wr_way;
                end
                if (kill[i]) begin
                    v_q[i] <= 1'b0;
                end else if (wr_hit[i]) begin
                    v_q[i] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_valid = v_q[rd_idx];
        rd_base  = base_q[rd_idx];
        rd_lo    = lo_q[rd_idx];
        rd_set   = set_q[rd_idx];
        rd_way   = way_q[rd_idx];
    end

endmodule

// File: rtl/elide_counter.sv
// Wrapping event counter.
module elide_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/breg_elide_unit.sv
module breg_elide_unit
    import breg_elide_pkg::*;
#(
    parameter int NUM_REGS   = 32,
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int SET_W      = 6,
    parameter int WAY_W      = 2,
    parameter int LINE_BYTES = 32,
    parameter int CNT_W      = 16,
    localparam int REG_W      = $clog2(NUM_REGS),
    localparam int LINE_SHIFT = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_off,
    output logic              rsp_valid,
    output logic              rsp_elide,
    output logic [SET_W-1:0]  rsp_set,
    output logic [WAY_W-1:0]  rsp_way,
    input  logic              fill_valid,
    input  logic [REG_W-1:0]  fill_reg,
    input  logic [ADDR_W-1:0] fill_base,
    input  logic [OFF_W-1:0]  fill_off,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic              rwr_valid,
    input  logic [REG_W-1:0]  rwr_reg,
    input  logic              evict_valid,
    input  logic [SET_W-1:0]  evict_set,
    input  logic [WAY_W-1:0]  evict_way,
    output logic [CNT_W-1:0]  elided_count,
    output logic [CNT_W-1:0]  full_count
);
    rsp_state_e state_q, state_d;

    logic              ent_valid;
    logic [ADDR_W-1:0] ent_base;
    logic [OFF_W:0]    ent_lo;
    logic [SET_W-1:0]  ent_set;
    logic [WAY_W-1:0]  ent_way;
    logic [OFF_W:0]    new_lo;
    logic              off_inside;
    logic              table_hit;
    logic [LINE_SHIFT-1:0] fill_byte;
    logic [SET_W-1:0]  hold_set_q;
    logic [WAY_W-1:0]  hold_way_q;

    // Byte position of the filled access inside its line (low bits only).
    assign fill_byte = fill_base[LINE_SHIFT-1:0] + fill_off[LINE_SHIFT-1:0];

    elide_table #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
        .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (req_reg),
        .rd_valid    (ent_valid),
        .rd_base     (ent_base),
        .rd_lo       (ent_lo),
        .rd_set      (ent_set),
        .rd_way      (ent_way),
        .wr_en       (fill_valid),
        .wr_idx      (fill_reg),
        .wr_base     (fill_base),
        .wr_lo       (new_lo),
        .wr_set      (fill_set),
        .wr_way      (fill_way),
        .clr_reg_en  (rwr_valid),
        .clr_reg_idx (rwr_reg),
        .clr_line_en (evict_valid),
        .clr_set     (evict_set),
        .clr_way     (evict_way)
    );

    elide_window #(.OFF_W(OFF_W), .LINE_SHIFT(LINE_SHIFT)) u_window (
        .fill_off  (fill_off),
        .fill_byte (fill_byte),
        .fill_lo   (new_lo),
        .chk_off   (req_off),
        .chk_lo    (ent_lo),
        .chk_in    (off_inside)
    );

    assign table_hit = ent_valid && (ent_base == req_base) && off_inside;

    // Next-state decision from the request and the table check.
    always_comb begin
        unique case ({req_valid, table_hit})
            2'b11:   state_d = RSP_ELIDE;
            2'b10:   state_d = RSP_FULL;
            default: state_d = RSP_IDLE;
        endcase
    end

    // State register plus the way/set held for an elide grant.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= RSP_IDLE;
            hold_set_q <= '0;
            hold_way_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == RSP_ELIDE) begin
                hold_set_q <= ent_set;
                hold_way_q <= ent_way;
            end
        end
    end

    // Outputs from the state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_elide = 1'b0;
        rsp_set   = '0;
        rsp_way   = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_ELIDE: begin
                rsp_valid = 1'b1;
                rsp_elide = 1'b1;
                rsp_set   = hold_set_q;
                rsp_way   = hold_way_q;
            end
            RSP_FULL: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    for (genvar k = 0; k < 2; k++) begin : g_cnt
        logic             bump;
        logic [CNT_W-1:0] value;
        assign bump = (state_d == ((k == 0) ? RSP_ELIDE : RSP_FULL));
        elide_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (bump),
            .count (value)
        );
    end
    assign elided_count = g_cnt[0].value;
    assign full_count   = g_cnt[1].value;

endmodule

// File: rtl/breg_elide_checker.sv
module breg_elide_checker #(
    parameter int REG_W = 5,
    parameter int SET_W = 6,
    parameter int WAY_W = 2,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [REG_W-1:0] req_reg,
    input logic             rwr_valid,
    input logic [REG_W-1:0] rwr_reg,
    input logic             rsp_valid,
    input logic             rsp_elide,
    input logic [SET_W-1:0] rsp_set,
    input logic [WAY_W-1:0] rsp_way,
    input logic [CNT_W-1:0] elided_count,
    input logic [CNT_W-1:0] full_count
);
    // R2/R3: a response only follows a request
    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R3: full response carries no set or way
    p_full_no_way_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_elide) |-> (rsp_set == '0 && rsp_way == '0));

    // R5: request right after a write to its register never elides
    p_rwr_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rwr_valid ##1 (req_valid && req_reg == $past(rwr_reg))) |=> (rsp_valid && !rsp_elide));

    // R8: elide response comes with one more elided count
    p_elide_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_elide) |-> (elided_count == CNT_W'($past(elided_count) + 1'b1)));

    // R8: full response comes with one more full count
    p_full_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_elide) |-> (full_count == CNT_W'($past(full_count) + 1'b1)));

    // R10: no response, counters hold
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(elided_count) && $stable(full_count)));

    // R2: elide flag never without valid
    p_elide_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_elide |-> rsp_valid);
endmodule

bind breg_elide_unit breg_elide_checker #(
    .REG_W(REG_W), .SET_W(SET_W), .WAY_W(WAY_W), .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_breg_elide_unit.sv
module test_breg_elide_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_reg = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_off = '0;
    logic        rsp_valid, rsp_elide;
    logic [5:0]  rsp_set;
    logic [1:0]  rsp_way;
    logic        fill_valid = 1'b0;
    logic [4:0]  fill_reg = '0;
    logic [31:0] fill_base = '0;
    logic [15:0] fill_off = '0;
    logic [5:0]  fill_set = '0;
    logic [1:0]  fill_way = '0;
    logic        rwr_valid = 1'b0;
    logic [4:0]  rwr_reg = '0;
    logic        evict_valid = 1'b0;
    logic [5:0]  evict_set = '0;
    logic [1:0]  evict_way = '0;
    logic [15:0] elided_count, full_count;

    breg_elide_unit i_breg_elide_unit (.*);

    always #4 clk = ~clk;

    // Behavioural reference table
    bit          m_v    [32];
    logic [31:0] m_base [32];
    logic [26:0] m_line [32];
    logic [5:0]  m_set  [32];
    logic [1:0]  m_way  [32];
    bit          e_valid, e_elide;
    logic [5:0]  e_set;
    logic [1:0]  e_way;
    int          e_cel, e_cfull;

    int    vectors = 0;
    int    miscompares = 0;
    bit    chk_on = 0;
    string tag = "R1";

    function automatic logic [31:0] sx(logic [15:0] o);
        return {{16{o[15]}}, o};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_v[i] = 0;
            e_valid = 0; e_elide = 0; e_set = 0; e_way = 0; e_cel = 0; e_cfull = 0;
        end else begin
            logic [31:0] a;
            a = req_base + sx(req_off);
            e_valid = req_valid; e_elide = 0; e_set = 0; e_way = 0;
            if (req_valid) begin
                if (m_v[req_reg] && m_base[req_reg] == req_base && m_line[req_reg] == a[31:5]) begin
                    e_elide = 1; e_set = m_set[req_reg]; e_way = m_way[req_reg];
                    e_cel = (e_cel + 1) % 65536;
                end else begin
                    e_cfull = (e_cfull + 1) % 65536;
                end
            end
            if (fill_valid) begin
                a = fill_base + sx(fill_off);
                m_v[fill_reg] = 1; m_base[fill_reg] = fill_base; m_line[fill_reg] = a[31:5];
                m_set[fill_reg] = fill_set; m_way[fill_reg] = fill_way;
            end
            if (rwr_valid) m_v[rwr_reg] = 0;
            if (evict_valid)
                for (int i = 0; i < 32; i++)
                    if (m_set[i] == evict_set && m_way[i] == evict_way) m_v[i] = 0;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            vectors++;
            if (rsp_valid !== e_valid) begin
                miscompares++;
                $display("FAIL %s rsp_valid got %0d exp %0d", tag, rsp_valid, e_valid);
            end
            if (rsp_elide !== e_elide) begin
                miscompares++;
                $display("FAIL %s rsp_elide got %0d exp %0d", tag, rsp_elide, e_elide);
            end
            if (rsp_set !== e_set || rsp_way !== e_way) begin
                miscompares++;
                $display("FAIL %s set/way got %0d/%0d exp %0d/%0d", tag, rsp_set, rsp_way, e_set, e_way);
            end
            if (elided_count !== 16'(e_cel) || full_count !== 16'(e_cfull)) begin
                miscompares++;
                $display("FAIL %s counts got %0d/%0d exp %0d/%0d", tag, elided_count, full_count, e_cel, e_cfull);
            end
        end
    end

    task automatic clr();
        req_valid = 0; fill_valid = 0; rwr_valid = 0; evict_valid = 0;
    endtask
    task automatic tick();
        @(negedge clk); clr();
    endtask
    task automatic set_req(input int r, input logic [31:0] b, input int o);
        req_valid = 1; req_reg = 5'(r); req_base = b; req_off = 16'(o);
    endtask
    task automatic set_fill(input int r, input logic [31:0] b, input int o, input int s, input int w);
        fill_valid = 1; fill_reg = 5'(r); fill_base = b; fill_off = 16'(o);
        fill_set = 6'(s); fill_way = 2'(w);
    endtask
    task automatic set_rwr(input int r);
        rwr_valid = 1; rwr_reg = 5'(r);
    endtask
    task automatic set_evict(input int s, input int w);
        evict_valid = 1; evict_set = 6'(s); evict_way = 2'(w);
    endtask
    task automatic look(input int r, input logic [31:0] b, input int o);
        set_req(r, b, o); tick();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired got running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_on = 1;
        // R1: reset state and cold lookups
        tag = "R1";
        tick();
        look(3, 32'h1000_0010, 4);
        look(0, 32'h0, 0);
        tick();
        // R4: window edges; base 0x1000_0010 off 4 -> line 0x1000_0000, window -16..15
        tag = "R4";
        set_fill(3, 32'h1000_0010, 4, 9, 1); tick();
        look(3, 32'h1000_0010, -16);
        look(3, 32'h1000_0010, 15);
        look(3, 32'h1000_0010, 16);
        look(3, 32'h1000_0010, -17);
        // R2: hit inside the window returns set 9 way 1
        tag = "R2";
        look(3, 32'h1000_0010, 0);
        // R9: other base value through the same register
        tag = "R9";
        look(3, 32'h1000_0011, 0);
        // R4: negative offsets across wrap at address 0
        tag = "R4";
        set_fill(4, 32'h0000_0004, -8, 2, 3); tick();
        look(4, 32'h0000_0004, -36);
        look(4, 32'h0000_0004, -5);
        look(4, 32'h0000_0004, -37);
        look(4, 32'h0000_0004, -4);
        // R5: register write clears; same-cycle fill and write
        tag = "R5";
        set_rwr(3); tick();
        look(3, 32'h1000_0010, 0);
        set_fill(3, 32'h1000_0010, 4, 9, 1); set_rwr(3); tick();
        look(3, 32'h1000_0010, 0);
        // R6: broadcast line clear
        tag = "R6";
        set_fill(5, 32'h200, 0, 7, 2); tick();
        set_fill(6, 32'h400, 0, 7, 2); tick();
        set_fill(7, 32'h600, 0, 7, 1); tick();
        set_evict(7, 2); tick();
        look(5, 32'h200, 1);
        look(6, 32'h400, 1);
        look(7, 32'h600, 1);
        set_fill(8, 32'h800, 0, 12, 0); set_evict(12, 0); tick();
        look(8, 32'h800, 0);
        // R7: request sees table before same-cycle updates
        tag = "R7";
        set_fill(9, 32'hA00, 0, 3, 3); set_req(9, 32'hA00, 0); tick();
        look(9, 32'hA00, 0);
        set_rwr(9); set_req(9, 32'hA00, 0); tick();
        look(9, 32'hA00, 0);
        set_fill(10, 32'hC00, 0, 4, 0); tick();
        set_evict(4, 0); set_req(10, 32'hC00, 2); tick();
        look(10, 32'hC00, 2);
        // R10: idle cycles
        tag = "R10";
        repeat (4) tick();
        // R3: random mixed stream over a few registers and bases
        tag = "R3";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] bases [3];
            bases[0] = 32'h100; bases[1] = 32'h11C; bases[2] = 32'hFFFF_FFF0;
            if ($urandom_range(0, 3) != 0)
                set_req($urandom_range(0, 3), bases[$urandom_range(0, 2)], $urandom_range(0, 80) - 40);
            if ($urandom_range(0, 3) == 0)
                set_fill($urandom_range(0, 3), bases[$urandom_range(0, 2)], $urandom_range(0, 80) - 40,
                         $urandom_range(0, 3), $urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) set_rwr($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) set_evict($urandom_range(0, 3), $urandom_range(0, 3));
            tick();
        end
        // R8: elided counter wrap past 2^16
        tag = "R8";
        set_fill(20, 32'h3000, 0, 1, 1); tick();
        for (int n = 0; n < 65600; n++) begin
            set_req(20, 32'h3000, n % 32); tick();
        end
        repeat (2) tick();
        chk_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule